// File: doc/BRIEF.md
# Machine Cycle Timing Generator

This block turns a free-running oscillator clock into the nested timing of a classic 8-bit microcontroller core. Every state lasts two oscillator periods. The first period of a state is phase one and the second is phase two. Six states make up one machine cycle, so a machine cycle lasts twelve oscillator periods. With a 12 MHz oscillator, one machine cycle is therefore 1 µs.

On top of this ring the block tracks instructions. An instruction takes one, two or four machine cycles. Most take one, and only multiply and divide take four. An instruction decoder outside the block presents a 2-bit length code. The block samples that code once, at the start of each instruction. It then reports which machine cycle of the instruction is running and raises a one-clock done pulse when the last cycle ends. Nothing inside the block decodes instructions.

Top module: `mcu_cycle_timer`

## Requirements
- R1: While `rst_n` is low, all outputs hold their reset values, and they take them at once without waiting for a clock edge: `state_oh_o` = 6'b000001 (S1), `phase_p2_o` = 0, `mcycle_stb_o` = 0, `instr_done_o` = 0 and `mcycle_idx_o` = 0. After `rst_n` rises, the outputs stay at S1, phase one for the next two rising edges, and timing advances on the third edge.
- R2: `state_oh_o` always has exactly one bit set. Bit i set means state S(i+1), so bit 0 is S1 and bit 5 is S6.
- R3: `phase_p2_o` is 0 in phase one and 1 in phase two, and it inverts on every clock. Each state therefore spans exactly two clocks, phase one first.
- R4: States run S1, S2, S3, S4, S5, S6 and then S1 again. One machine cycle lasts exactly 12 clocks.
- R5: `mcycle_stb_o` is high for exactly one clock in every machine cycle, namely the clock in S6, phase two.
- R6: The length code `cyc_len_i` uses 2'b00 for one cycle, 2'b01 for two cycles and 2'b10 for four cycles. The value 2'b11 is reserved and behaves as one cycle. The code is captured on the rising edge that ends S1, phase one, of the first machine cycle of each instruction.
- R7: A value on `cyc_len_i` at any other clock edge has no effect on the instruction in progress.
- R8: `instr_done_o` is high for one clock, together with `mcycle_stb_o`, in the last machine cycle of each instruction. It is never high at any other time.
- R9: `mcycle_idx_o` gives the zero-based number of the machine cycle now running within the instruction. It steps up after each strobe and returns to 0 after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cyc_len_i | input | 2 | Machine-cycle count code for the instruction about to start |
| state_oh_o | output | 6 | One-hot state index, bit 0 = S1 |
| phase_p2_o | output | 1 | 0 in phase one, 1 in phase two |
| mcycle_stb_o | output | 1 | One-clock strobe in S6, phase two |
| instr_done_o | output | 1 | One-clock pulse at the strobe of the last machine cycle |
| mcycle_idx_o | output | 2 | Machine cycle index within the current instruction |

## Verification
The embedded assertions check the local invariants on every clock:
- the state vector stays one-hot;
- a state holds through phase one and moves on after phase two;
- the strobe appears only in S6, phase two;
- done never occurs without the strobe;
- the cycle index stays within the captured length;
- the captured length stays fixed after the first machine cycle.

Only the directed scenarios can show the properties that depend on a whole sequence. These are the exact 12-clock and 12·L-clock periods for each length code, and the treatment of the reserved code. They also include the claim that a code changed mid-instruction is ignored, and the asynchronous reset taken in the middle of an instruction followed by the two-edge delay before timing resumes.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;

  localparam int unsigned STATES_PER_MC = 6;
  localparam int unsigned MAX_MC        = 4;
  localparam int unsigned MC_W          = $clog2(MAX_MC);

  typedef enum logic [1:0] {
    LEN_1   = 2'b00,
    LEN_2   = 2'b01,
    LEN_4   = 2'b10,
    LEN_RSV = 2'b11
  } cyc_len_e;

  // Index of the final machine cycle for a length code (reserved -> single).
  function automatic logic [MC_W-1:0] last_mc(input cyc_len_e len);
    logic [MC_W-1:0] r;
    case (len)
      LEN_2:   r = MC_W'(1);
      LEN_4:   r = MC_W'(MAX_MC - 1);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mct_rst_sync.sv
`timescale 1ns/1ps
module mct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_q_n = shift_q[STAGES-1];

endmodule

// File: rtl/mct_state_gen.sv
`timescale 1ns/1ps
module mct_state_gen #(
  parameter int unsigned N_STATES = 6
) (
  input  logic                clk,
  input  logic                rst_q_n,
  output logic [N_STATES-1:0] state_oh_o,
  output logic                phase_p2_o,
  output logic                mcycle_stb_o
);

  logic [N_STATES-1:0] st_q, st_d;
  logic                ph_q, ph_d;
  logic                stb_q, stb_d;
  logic                st_en;

  // State register only moves at the end of phase two.
  assign st_en = ph_q;

  always_comb begin
    ph_d  = ~ph_q;
    st_d  = {st_q[N_STATES-2:0], st_q[N_STATES-1]};
    // Strobe becomes visible in the final state, phase two.
    stb_d = st_q[N_STATES-1] & ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ph_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   st_q <= N_STATES'(1);
    else if (st_en) st_q <= st_d;
  end

  assign state_oh_o   = st_q;
  assign phase_p2_o   = ph_q;
  assign mcycle_stb_o = stb_q;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(state_oh_o) == 1);

  p_state_hold_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !phase_p2_o |=> $stable(state_oh_o) && phase_p2_o);

  p_state_adv_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_p2_o |=> (state_oh_o != $past(state_oh_o)) && !phase_p2_o);

endmodule

// File: rtl/mct_instr_tracker.sv
`timescale 1ns/1ps
module mct_instr_tracker
  import mct_pkg::*;
#(
  parameter int unsigned N_STATES = 6
) (
  input  logic                clk,
  input  logic                rst_q_n,
  input  logic [1:0]          cyc_len_i,
  input  logic [N_STATES-1:0] state_oh_i,
  input  logic                phase_p2_i,
  input  logic                mcycle_stb_i,
  output logic                instr_done_o,
  output logic [MC_W-1:0]     mcycle_idx_o
);

  cyc_len_e        len_q;
  logic [MC_W-1:0] cnt_q, cnt_d;
  logic            done_q, done_d;
  logic            len_en;
  logic            cnt_en;
  logic [MC_W-1:0] last_idx;

  // Capture window: first state, phase one, first machine cycle.
  assign len_en   = state_oh_i[0] & ~phase_p2_i & (cnt_q == '0);
  assign cnt_en   = mcycle_stb_i;
  assign last_idx = last_mc(len_q);

  always_comb begin
    done_d = state_oh_i[N_STATES-1] & ~phase_p2_i & (cnt_q == last_idx);
    cnt_d  = done_q ? '0 : cnt_q + MC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    len_q <= LEN_1;
    else if (len_en) len_q <= cyc_len_e'(cyc_len_i);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) done_q <= 1'b0;
    else          done_q <= done_d;
  end

  assign instr_done_o = done_q;
  assign mcycle_idx_o = cnt_q;

  p_stb_pos_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    mcycle_stb_i |-> state_oh_i[N_STATES-1] && phase_p2_i);

  p_done_stb_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    instr_done_o |-> mcycle_stb_i);

  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mcycle_idx_o != '0) |-> $stable(len_q));

  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    mcycle_idx_o <= last_idx);

  p_idx_wrap_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    instr_done_o |=> mcycle_idx_o == '0);

endmodule

// File: rtl/mcu_cycle_timer.sv
`timescale 1ns/1ps
module mcu_cycle_timer
  import mct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cyc_len_i,
  output logic [STATES_PER_MC-1:0] state_oh_o,
  output logic                     phase_p2_o,
  output logic                     mcycle_stb_o,
  output logic                     instr_done_o,
  output logic [MC_W-1:0]          mcycle_idx_o
);

  logic rst_q_n;

  mct_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mct_state_gen #(.N_STATES(STATES_PER_MC)) u_state (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .state_oh_o   (state_oh_o),
    .phase_p2_o   (phase_p2_o),
    .mcycle_stb_o (mcycle_stb_o)
  );

  mct_instr_tracker #(.N_STATES(STATES_PER_MC)) u_instr (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .cyc_len_i    (cyc_len_i),
    .state_oh_i   (state_oh_o),
    .phase_p2_i   (phase_p2_o),
    .mcycle_stb_i (mcycle_stb_o),
    .instr_done_o (instr_done_o),
    .mcycle_idx_o (mcycle_idx_o)
  );

endmodule

// File: tb/tb_mcu_cycle_timer.sv
`timescale 1ns/1ps
module tb_mcu_cycle_timer;

  logic       clk;
  logic       rst_n;
  logic [1:0] cyc_len_i;
  logic [5:0] state_oh_o;
  logic       phase_p2_o;
  logic       mcycle_stb_o;
  logic       instr_done_o;
  logic [1:0] mcycle_idx_o;

  int n_chk;
  int n_bad;

  mcu_cycle_timer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_len_i    (cyc_len_i),
    .state_oh_o   (state_oh_o),
    .phase_p2_o   (phase_p2_o),
    .mcycle_stb_o (mcycle_stb_o),
    .instr_done_o (instr_done_o),
    .mcycle_idx_o (mcycle_idx_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset_vals(input string req);
    chk({req, " state"}, int'(state_oh_o), 1);
    chk({req, " phase"}, int'(phase_p2_o), 0);
    chk({req, " stb"},   int'(mcycle_stb_o), 0);
    chk({req, " done"},  int'(instr_done_o), 0);
    chk({req, " idx"},   int'(mcycle_idx_o), 0);
  endtask

  // Release at a negedge; timing advances on the third rising edge.
  task automatic release_reset();
    rst_n = 1'b1;
    chk_reset_vals("R1 release");
    repeat (2) begin
      @(negedge clk);
      chk_reset_vals("R1 sync hold");
    end
  endtask

  // Called at a negedge showing S1 P1 idx 0; length applied for clock k=0.
  task automatic run_instr(input logic [1:0] code, input int n_mc,
                           input bit scramble, input string tag);
    cyc_len_i = code;
    for (int k = 0; k < 12 * n_mc; k++) begin
      int pos;
      pos = k % 12;
      chk({tag, " R2/R4 state"}, int'(state_oh_o), 1 << (pos / 2));
      chk({tag, " R3 phase"},    int'(phase_p2_o), pos % 2);
      chk({tag, " R5 stb"},      int'(mcycle_stb_o), (pos == 11) ? 1 : 0);
      chk({tag, " R6/R8 done"},  int'(instr_done_o), (k == 12 * n_mc - 1) ? 1 : 0);
      chk({tag, " R9 idx"},      int'(mcycle_idx_o), k / 12);
      if (scramble && k >= 1) cyc_len_i = 2'(k);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc_len_i = 2'b00;
    repeat (3) @(negedge clk);
    chk_reset_vals("R1 in reset");
    release_reset();
  endtask

  task automatic t_one();   run_instr(2'b00, 1, 1'b0, "single");   endtask
  task automatic t_two();   run_instr(2'b01, 2, 1'b0, "double");   endtask
  task automatic t_four();  run_instr(2'b10, 4, 1'b0, "quad");     endtask
  task automatic t_rsv();   run_instr(2'b11, 1, 1'b0, "R6 rsv");   endtask

  task automatic t_ignore();
    run_instr(2'b10, 4, 1'b1, "R7 quad");
    run_instr(2'b00, 1, 1'b1, "R7 single");
    run_instr(2'b01, 2, 1'b1, "R7 double");
  endtask

  task automatic t_mix();
    run_instr(2'b01, 2, 1'b0, "mix a");
    run_instr(2'b00, 1, 1'b0, "mix b");
    run_instr(2'b10, 4, 1'b0, "mix c");
    run_instr(2'b00, 1, 1'b0, "mix d");
  endtask

  task automatic t_mid_reset();
    cyc_len_i = 2'b10;
    repeat (17) @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.2 chk_reset_vals("R1 async");
    @(negedge clk);
    chk_reset_vals("R1 held");
    release_reset();
    run_instr(2'b01, 2, 1'b0, "R1 resume");
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_one();
    t_two();
    t_four();
    t_rsv();
    t_ignore();
    t_mix();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule